// File: doc/BRIEF.md
# Longest Prefix Match Trie Lookup Engine

This block picks the output interface for a packet by finding the longest stored prefix that matches its destination address. The prefixes are held as a binary trie in an on-chip node memory. A lookup walks the trie one address bit per clock, starting at the most significant bit, and keeps the port of the deepest prefix-bearing node it has passed. The walk stops when the next child is null or when every address bit has been used. The engine then reports the remembered port, or a miss.

Software builds the trie elsewhere and loads it node by node through a simple write port while the engine is idle. Node 0 is always the root. Each node holds a left-child index, a right-child index, a prefix-present flag and a port number. A child index of 0 means the child is null. One lookup is in flight at a time. Its latency equals the number of nodes visited, so a lookup takes at most the address width plus one cycles.

Top module: `lpm_trie_walker`

## Requirements
- R1: After reset `busy`, `resp_valid`, `resp_hit` and `resp_port` are 0, and every node memory word is cleared, so a lookup on a freshly reset engine misses.
- R2: The response carries the port of the longest stored prefix that matches the address, and `resp_hit`=1. When a short prefix and a longer prefix both match, the longer one wins.
- R3: If the walk passes no node whose prefix flag is set, the response has `resp_hit`=0 and `resp_port`=0.
- R4: The walk starts at node 0 and uses the address from bit ADDR_W-1 downward. A 0 bit follows the left child and a 1 bit follows the right child. A child index of 0 ends the walk.
- R5: Let k be the number of nodes visited (1 to ADDR_W+1). `resp_valid` rises k rising edges after the edge that accepts the request. `busy` is high in between.
- R6: A request is accepted only when `busy` is 0. A `req_valid` seen while busy is ignored: it does not change the lookup in progress and produces no extra response.
- R7: A node write (`wr_en`) takes effect only while `busy` is 0. A write presented while busy leaves the node unchanged.
- R8: Each accepted request produces exactly one `resp_valid` pulse, one cycle wide. `busy` falls on the same edge that raises it.
- R9: A prefix flag set on node 0 acts as a zero-length default route that matches every address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Destination address to look up |
| busy | output | 1 | Walk in progress; requests and writes are ignored |
| resp_valid | output | 1 | One-cycle pulse marking a result |
| resp_port | output | PORT_W | Selected output interface (0 on a miss) |
| resp_hit | output | 1 | 1 when some prefix matched |
| wr_en | input | 1 | Node write strobe |
| wr_idx | input | IDX_W | Node index to write |
| wr_left | input | IDX_W | Left (bit 0) child index, 0 = null |
| wr_right | input | IDX_W | Right (bit 1) child index, 0 = null |
| wr_pfx | input | 1 | Node ends a stored prefix |
| wr_port | input | PORT_W | Port for that prefix |

## Verification
The assertions assume only that the inputs carry known values once reset is released. The latency bound and the pulse rules hold even for a badly formed node table, because the walk is limited by the bit count and not by the shape of the links. Best-match results only make sense for a tree whose links point downward. The bench therefore builds each table by inserting prefixes into a proper trie. It breaks the timing rules only on purpose, by issuing a request and a write while busy, and it checks afterwards that neither had any effect.

// File: rtl/lpm_trie_walker.sv
module lpm_trie_walker #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 7,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              resp_valid,
  output logic [PORT_W-1:0] resp_port,
  output logic              resp_hit,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_left,
  input  logic [IDX_W-1:0]  wr_right,
  input  logic              wr_pfx,
  input  logic [PORT_W-1:0] wr_port
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int NODE_W = 2 * IDX_W + 1 + PORT_W;
  localparam int USED_W = $clog2(ADDR_W + 1) + 1;

  logic [NODE_W-1:0] mem [DEPTH];

  logic              busy_q;
  logic [ADDR_W-1:0] key_q;
  logic [IDX_W-1:0]  cur_q;
  logic [USED_W-1:0] used_q;
  logic [PORT_W-1:0] best_port_q;
  logic              best_hit_q;
  logic              rv_q;
  logic [PORT_W-1:0] rport_q;
  logic              rhit_q;

  logic [NODE_W-1:0] node;
  logic [IDX_W-1:0]  n_left, n_right, n_next;
  logic              n_pfx;
  logic [PORT_W-1:0] n_port;
  logic              done;
  logic              hit_now;
  logic [PORT_W-1:0] port_now;

  assign node    = mem[cur_q];
  assign n_left  = node[NODE_W-1 -: IDX_W];
  assign n_right = node[NODE_W-1-IDX_W -: IDX_W];
  assign n_pfx   = node[PORT_W];
  assign n_port  = node[PORT_W-1:0];

  assign n_next   = key_q[ADDR_W-1] ? n_right : n_left;
  assign done     = (used_q == USED_W'(ADDR_W)) || (n_next == '0);
  assign hit_now  = best_hit_q | n_pfx;
  assign port_now = n_pfx ? n_port : best_port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      busy_q      <= 1'b0;
      key_q       <= '0;
      cur_q       <= '0;
      used_q      <= '0;
      best_port_q <= '0;
      best_hit_q  <= 1'b0;
      rv_q        <= 1'b0;
      rport_q     <= '0;
      rhit_q      <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (!busy_q) begin
        if (wr_en) mem[wr_idx] <= {wr_left, wr_right, wr_pfx, wr_port};
        if (req_valid) begin
          busy_q      <= 1'b1;
          key_q       <= req_addr;
          cur_q       <= '0;
          used_q      <= '0;
          best_port_q <= '0;
          best_hit_q  <= 1'b0;
        end
      end else begin
        best_port_q <= port_now;
        best_hit_q  <= hit_now;
        if (done) begin
          busy_q  <= 1'b0;
          rv_q    <= 1'b1;
          rport_q <= port_now;
          rhit_q  <= hit_now;
        end else begin
          cur_q  <= n_next;
          key_q  <= key_q << 1;
          used_q <= used_q + 1'b1;
        end
      end
    end
  end

  assign busy       = busy_q;
  assign resp_valid = rv_q;
  assign resp_port  = rport_q;
  assign resp_hit   = rhit_q;
endmodule

// File: rtl/lpm_trie_walker_chk.sv
module lpm_trie_walker_chk #(
  parameter int ADDR_W = 8,
  parameter int PORT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic [PORT_W-1:0] resp_port
);
  localparam int CW = $clog2(ADDR_W + 2) + 1;
  logic [CW-1:0] walk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) walk_cnt <= '0;
    else                 walk_cnt <= walk_cnt + 1'b1;
  end

  a_r5_latency_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> walk_cnt <= CW'(ADDR_W));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  a_r8_resp_ends_walk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(busy) && !busy));
  a_r8_walk_yields_resp: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || resp_valid));
  a_r3_miss_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> resp_port == '0);
  a_r6_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
endmodule

bind lpm_trie_walker lpm_trie_walker_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_port(resp_port));

// File: tb/test_lpm_trie_walker.sv
module test_lpm_trie_walker;
  localparam int AW = 8;
  localparam int IW = 7;
  localparam int PW = 4;
  localparam int NMAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic busy, resp_valid, resp_hit;
  logic [PW-1:0] resp_port;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0, wr_left = '0, wr_right = '0;
  logic wr_pfx = 1'b0;
  logic [PW-1:0] wr_port = '0;

  lpm_trie_walker #(.ADDR_W(AW), .IDX_W(IW), .PORT_W(PW)) i_lpm_trie_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .resp_valid(resp_valid), .resp_port(resp_port), .resp_hit(resp_hit),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_left(wr_left), .wr_right(wr_right),
    .wr_pfx(wr_pfx), .wr_port(wr_port));

  always #2ns clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // prefix list (reference) and bench-side trie for node allocation
  logic [AW-1:0] pv [NMAX];
  int            pl [NMAX];
  int            pp [NMAX];
  int            np = 0;
  int            tl [1<<IW], tr [1<<IW], tp [1<<IW];
  bit            tf [1<<IW];
  int            nfree = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clz_match(input logic [AW-1:0] a, input logic [AW-1:0] b);
    int n = 0;
    for (int i = AW - 1; i >= 0; i--) begin
      if (a[i] != b[i]) return n;
      n++;
    end
    return n;
  endfunction

  function automatic void ref_lookup(input logic [AW-1:0] a, output int port,
                                     output bit hit, output int lat);
    int best = -1;
    int d = 0;
    port = 0; hit = 1'b0;
    for (int i = 0; i < np; i++) begin
      int m = clz_match(a, pv[i]);
      int md = (m < pl[i]) ? m : pl[i];
      if (md > d) d = md;
      if (m >= pl[i] && pl[i] >= best) begin
        best = pl[i]; port = pp[i]; hit = 1'b1;
      end
    end
    lat = d + 1;
  endfunction

  task automatic write_node(input int idx);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_left = IW'(tl[idx]); wr_right = IW'(tr[idx]);
    wr_pfx = tf[idx]; wr_port = PW'(tp[idx]);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic insert(input logic [AW-1:0] v, input int len, input int port);
    int cur = 0;
    for (int i = 0; i < len; i++) begin
      bit b = v[AW-1-i];
      int ch = b ? tr[cur] : tl[cur];
      if (ch == 0) begin
        ch = nfree++;
        if (b) tr[cur] = ch; else tl[cur] = ch;
        write_node(cur);
      end
      cur = ch;
    end
    tf[cur] = 1'b1; tp[cur] = port;
    write_node(cur);
    pv[np] = v; pl[np] = len; pp[np] = port; np++;
  endtask

  task automatic clear_tables();
    np = 0; nfree = 1;
    for (int i = 0; i < (1 << IW); i++) begin
      tl[i] = 0; tr[i] = 0; tp[i] = 0; tf[i] = 1'b0;
    end
  endtask

  task automatic lookup(input logic [AW-1:0] a, output int port, output bit hit, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    port = int'(resp_port); hit = resp_hit;
  endtask

  task automatic check_lookup(input logic [AW-1:0] a, input string tag);
    int p, l, ep, el;
    bit h, eh;
    lookup(a, p, h, l);
    ref_lookup(a, ep, eh, el);
    check(p == ep, {tag, " port"}, p, ep);
    check(h == eh, {tag, " hit"}, int'(h), int'(eh));
    check(l == el, {"R5 latency ", tag}, l, el);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_tables();
  endtask

  initial begin
    int p, l, pulses, cap;
    bit h;
    void'($urandom(32'd4711));
    clear_tables();
    do_reset();
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(resp_valid == 1'b0, "R1 resp_valid after reset", int'(resp_valid), 0);
    check(resp_hit == 1'b0 && resp_port == '0, "R1 resp after reset", int'(resp_port), 0);
    lookup(8'hA5, p, h, l);
    check(h == 1'b0 && p == 0, "R1 empty trie misses", p, 0);
    check(l == 1, "R5 empty trie latency", l, 1);

    // directed example table over top five bits
    insert(8'b00100000, 3, 2);
    insert(8'b01000000, 4, 3);
    insert(8'b10000000, 2, 1);
    insert(8'b01100000, 5, 5);
    check_lookup(8'b00110000, "R2 example 00110");
    check_lookup(8'b01001000, "R2 example 01001");
    check_lookup(8'b01100000, "R2 example 01100");
    check_lookup(8'b10111000, "R2 example 10111");
    check_lookup(8'b11000000, "R3 miss");
    lookup(8'b11000000, p, h, l);
    check(h == 1'b0 && p == 0, "R3 miss gives port 0", p, 0);
    check(l == 2, "R4 right child null ends walk", l, 2);

    // nested prefixes: longer wins (R2), full-depth walk (R5)
    insert(8'b11010000, 4, 6);
    insert(8'b11010110, 8, 9);
    check_lookup(8'b11010110, "R2 longest of nested");
    check_lookup(8'b11010111, "R2 shorter of nested");
    lookup(8'b11010110, p, h, l);
    check(l == AW + 1, "R5 full depth latency", l, AW + 1);

    // request and write while busy are ignored (R6, R7)
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'b01100000;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 8'b00110000;
    wr_en = 1'b1; wr_idx = '0; wr_left = IW'(tl[0]); wr_right = IW'(tr[0]);
    wr_pfx = 1'b1; wr_port = 4'd12;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    pulses = 0; cap = -1;
    repeat (14) begin
      if (resp_valid) begin pulses++; cap = int'(resp_port); end
      @(negedge clk);
    end
    check(pulses == 1, "R8 one pulse per accepted request", pulses, 1);
    check(cap == 5, "R6 busy request ignored", cap, 5);
    lookup(8'b11000000, p, h, l);
    check(h == 1'b0 && p == 0, "R7 busy write ignored", p, 0);

    // default route on root (R9)
    insert(8'h00, 0, 7);
    check_lookup(8'b11000000, "R9 default route");
    check_lookup(8'b01100000, "R9 longer beats default");

    // random tables
    for (int t = 0; t < 4; t++) begin
      do_reset();
      for (int k = 0; k < 10; k++)
        insert(AW'($urandom), int'($urandom % (AW + 1)), 1 + int'($urandom % 15));
      for (int k = 0; k < 60; k++) begin
        logic [AW-1:0] a = AW'($urandom);
        if (k % 2 == 0) begin
          int j = int'($urandom % np);
          int sh = AW - pl[j];
          a = (sh >= AW) ? a : ((pv[j] >> sh) << sh) | (a & ((AW'(1) << sh) - 1'b1));
        end
        check_lookup(a, "R2 random");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule